// File: doc/BRIEF.md
# Transmit Jabber Protection Timer

This block guards a twisted-pair transmitter against a MAC that holds its transmit enable too long. It counts how many consecutive clock edges the transmit enable stays high. When the count reaches the jabber limit, the block latches a jabber condition and closes the transmit gate. The gate stays closed for as long as transmit enable remains high, however long that is. It opens again only after transmit enable has been low without a break for a long quiet interval. Any high sample during that interval starts the quiet count over.

A configuration input switches the protection off entirely. While it is high, the gate simply follows transmit enable. Raising it during a jabber event releases the transmitter at once and throws the jabber state away. A jabber flag reports the latched condition. In half-duplex operation the same flag also drives a collision indication toward the MAC. Both limits are cycle-count parameters. The defaults match a 24 ms limit and a 256 ms quiet interval at a 250 MHz clock, and a bench can override them with small values.

The control is a five-state machine:
- IDLE: not jabbered, transmit enable low.
- RUN: counting consecutive high samples.
- JAM: jabbered while transmit enable is high.
- QUIET: jabbered while counting consecutive low samples.
- BYPASS: protection switched off.

Its transitions are:
- IDLE or BYPASS to RUN when transmit enable is high.
- RUN to IDLE on a low sample.
- RUN to JAM when the high count reaches the limit.
- JAM to QUIET on a low sample.
- QUIET to JAM on a high sample.
- QUIET to IDLE when the quiet count completes.
- Any state to BYPASS while the disable input is high.
- BYPASS to IDLE when the disable input is low and transmit enable is low.

Top module: `tx_jabber_guard`

## Requirements
- R1: While not jabbered and with `jab_off` low, `tx_gate` equals `tx_en` in the same cycle and `jab_flag` is 0.
- R2: Once `tx_en` has been sampled high on `JAB_CYCLES` consecutive rising edges with `jab_off` low, `jab_flag` is 1 and `tx_gate` is 0 after the last of those edges. A run of `JAB_CYCLES`-1 high samples does not jabber.
- R3: A single low sample of `tx_en` clears the high-run count, so two runs each shorter than `JAB_CYCLES` never jabber.
- R4: While jabbered, `tx_gate` stays 0 and `jab_flag` stays 1 for every cycle that `tx_en` stays high, with no time limit.
- R5: The jabber clears after `tx_en` has been sampled low on `UNJAB_CYCLES` consecutive rising edges. From the cycle after the last of those edges, `jab_flag` is 0 and `tx_gate` follows `tx_en` again.
- R6: A high sample of `tx_en` during the quiet interval restarts the quiet count from zero. This holds even on the edge where the count would otherwise have completed.
- R7: `col_jab` equals `jab_flag` when `half_duplex` is 1 and is 0 when `half_duplex` is 0.
- R8: While `jab_off` is 1, `tx_gate` equals `tx_en` and `jab_flag` is 0 in the same cycle. A jabber state present when it rises is discarded at the next edge.
- R9: No high samples accumulate while `jab_off` is 1. After it falls, a jabber needs a full run of `JAB_CYCLES` fresh high samples.
- R10: Asynchronous active-low reset returns the block to the not-jabbered state. With `tx_en` low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| jab_off | input | 1 | Switches jabber protection off when 1 |
| half_duplex | input | 1 | 1 selects half-duplex operation |
| tx_gate | output | 1 | Enable for the transmitter output stage |
| jab_flag | output | 1 | Jabber condition is latched |
| col_jab | output | 1 | Collision indication caused by jabber (half duplex only) |

## Verification
Two pairs of functions can land on the same clock edge, and the bench provokes both with exact cycle counts.

The first pair is the end of the quiet count and a restart. The bench holds `tx_en` low for `UNJAB_CYCLES`-1 edges and raises it on the edge that would have released the gate. The scoreboard then expects `jab_flag` to stay 1 and the release to need a full fresh quiet run.

The second pair is the jabber trip and the disable input. The bench raises `jab_off` in the same cycle as the `JAB_CYCLES`-th high sample. It expects no jabber at all, and a fresh full run to be needed after `jab_off` drops.

// File: rtl/tjg_pkg.sv
package tjg_pkg;

    // Control states of the jabber guard
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,   // not jabbered, transmit enable low
        ST_RUN    = 3'd1,   // counting consecutive high samples
        ST_JAM    = 3'd2,   // jabbered, transmit enable high
        ST_QUIET  = 3'd3,   // jabbered, counting consecutive low samples
        ST_BYPASS = 3'd4    // protection switched off
    } tjg_state_e;

endpackage

// File: rtl/tjg_counter.sv
module tjg_counter #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);

    // Shared run-length counter: the high run and the quiet run never overlap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CW'(1);
        end
    end

endmodule

// File: rtl/tjg_fsm.sv
module tjg_fsm
    import tjg_pkg::*;
#(
    parameter int unsigned JAB_CYCLES   = 6_000_000,
    parameter int unsigned UNJAB_CYCLES = 64_000_000,
    parameter int unsigned CW           = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          jab_off,
    input  logic [CW-1:0] count,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output tjg_state_e    state
);

    localparam logic [CW-1:0] JAB_LAST   = CW'(JAB_CYCLES - 1);
    localparam logic [CW-1:0] UNJAB_LAST = CW'(UNJAB_CYCLES - 1);

    tjg_state_e state_d;
    logic       jab_hit;
    logic       quiet_hit;

    assign jab_hit   = (count == JAB_LAST);
    assign quiet_hit = (count == UNJAB_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Next state and counter control
    always_comb begin
        state_d = state;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (jab_off) begin
            state_d = ST_BYPASS;
            cnt_clr = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE, ST_BYPASS: begin
                    if (tx_en) begin
                        state_d = ST_RUN;
                        cnt_inc = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                        cnt_clr = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!tx_en) begin
                        state_d = ST_IDLE;
                        cnt_clr = 1'b1;
                    end else if (jab_hit) begin
                        state_d = ST_JAM;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_JAM: begin
                    if (!tx_en) begin
                        state_d = ST_QUIET;
                        cnt_inc = 1'b1;
                    end else begin
                        cnt_clr = 1'b1;
                    end
                end
                ST_QUIET: begin
                    if (tx_en) begin
                        state_d = ST_JAM;
                        cnt_clr = 1'b1;
                    end else if (quiet_hit) begin
                        state_d = ST_IDLE;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/tjg_outputs.sv
module tjg_outputs
    import tjg_pkg::*;
(
    input  tjg_state_e state,
    input  logic       tx_en,
    input  logic       jab_off,
    input  logic       half_duplex,
    output logic       tx_gate,
    output logic       jab_flag,
    output logic       col_jab
);

    // Output decode; the disable input acts in the same cycle
    always_comb begin
        tx_gate  = 1'b0;
        jab_flag = 1'b0;
        unique case (state)
            ST_JAM, ST_QUIET: begin
                jab_flag = !jab_off;
                tx_gate  = tx_en && jab_off;
            end
            default: begin
                jab_flag = 1'b0;
                tx_gate  = tx_en;
            end
        endcase
        col_jab = half_duplex && jab_flag;
    end

endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard #(
    parameter int unsigned JAB_CYCLES   = 6_000_000,   // 24 ms at 250 MHz, must be >= 2
    parameter int unsigned UNJAB_CYCLES = 64_000_000   // 256 ms at 250 MHz, must be >= 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic jab_off,
    input  logic half_duplex,
    output logic tx_gate,
    output logic jab_flag,
    output logic col_jab
);

    localparam int unsigned MAX_LIM = (JAB_CYCLES > UNJAB_CYCLES) ? JAB_CYCLES : UNJAB_CYCLES;
    localparam int unsigned CW      = $clog2(MAX_LIM + 1);

    tjg_pkg::tjg_state_e state;
    logic [CW-1:0]       count;
    logic                cnt_clr;
    logic                cnt_inc;

    tjg_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (count)
    );

    tjg_fsm #(
        .JAB_CYCLES   (JAB_CYCLES),
        .UNJAB_CYCLES (UNJAB_CYCLES),
        .CW           (CW)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .jab_off (jab_off),
        .count   (count),
        .cnt_clr (cnt_clr),
        .cnt_inc (cnt_inc),
        .state   (state)
    );

    tjg_outputs u_out (
        .state       (state),
        .tx_en       (tx_en),
        .jab_off     (jab_off),
        .half_duplex (half_duplex),
        .tx_gate     (tx_gate),
        .jab_flag    (jab_flag),
        .col_jab     (col_jab)
    );

endmodule

// File: rtl/tjg_checker.sv
module tjg_checker #(
    parameter int unsigned JAB_CYCLES   = 6_000_000,
    parameter int unsigned UNJAB_CYCLES = 64_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic jab_off,
    input logic half_duplex,
    input logic tx_gate,
    input logic jab_flag,
    input logic col_jab
);

    // Independent run-length trackers, saturating
    logic [31:0] hi_run;
    logic [31:0] lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            if (tx_en && !jab_off) begin
                if (hi_run != '1) hi_run <= hi_run + 32'd1;
            end else begin
                hi_run <= '0;
            end
            if (!tx_en) begin
                if (lo_run != '1) lo_run <= lo_run + 32'd1;
            end else begin
                lo_run <= '0;
            end
        end
    end

    p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!jab_flag && !jab_off) |-> (tx_gate == tx_en));

    p_trip_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jab_flag) |-> (hi_run >= 32'(JAB_CYCLES)));

    p_gate_shut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        jab_flag |-> !tx_gate);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (jab_flag && tx_en) |=> (jab_flag || jab_off));

    p_quiet_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(jab_flag) && !jab_off) |-> (lo_run >= 32'(UNJAB_CYCLES)));

    p_col_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        col_jab |-> (half_duplex && jab_flag));

    p_col_hd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (half_duplex && jab_flag) |-> col_jab);

    p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        jab_off |-> (!jab_flag && (tx_gate == tx_en)));

endmodule

bind tx_jabber_guard tjg_checker #(
    .JAB_CYCLES   (JAB_CYCLES),
    .UNJAB_CYCLES (UNJAB_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .jab_off     (jab_off),
    .half_duplex (half_duplex),
    .tx_gate     (tx_gate),
    .jab_flag    (jab_flag),
    .col_jab     (col_jab)
);

// File: tb/tx_jabber_guard_tb.sv
`timescale 1ns/1ps
module tx_jabber_guard_tb;

    localparam int unsigned JAB   = 20;
    localparam int unsigned UNJAB = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic jab_off = 1'b0;
    logic half_duplex = 1'b1;
    logic tx_gate;
    logic jab_flag;
    logic col_jab;

    always #2 clk = ~clk;   // 250 MHz

    tx_jabber_guard #(.JAB_CYCLES(JAB), .UNJAB_CYCLES(UNJAB)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .jab_off     (jab_off),
        .half_duplex (half_duplex),
        .tx_gate     (tx_gate),
        .jab_flag    (jab_flag),
        .col_jab     (col_jab)
    );

    typedef struct {
        logic  gate;
        logic  flag;
        logic  col;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    // Behavioural model state from the requirements
    bit m_jab = 1'b0;
    int m_hi  = 0;
    int m_lo  = 0;

    task automatic check_now(input logic g, input logic f, input logic c, input string tag);
        n_chk++;
        if (tx_gate !== g || jab_flag !== f || col_jab !== c) begin
            n_err++;
            $display("FAIL %s: gate/flag/col actual %b%b%b expected %b%b%b",
                     tag, tx_gate, jab_flag, col_jab, g, f, c);
        end
    endtask

    // Driver: apply one cycle of stimulus, push the expectation, advance the model
    task automatic step(input logic tx, input logic off, input logic hd, input string tag);
        exp_t e;
        @(negedge clk);
        tx_en = tx;
        jab_off = off;
        half_duplex = hd;
        e.flag = m_jab && !off;
        e.gate = tx && (off || !m_jab);
        e.col  = hd && e.flag;
        e.tag  = tag;
        sb_q.push_back(e);
        if (off) begin
            m_jab = 1'b0;
            m_hi  = 0;
            m_lo  = 0;
        end else if (!m_jab) begin
            if (tx) begin
                m_hi++;
                if (m_hi >= int'(JAB)) begin
                    m_jab = 1'b1;
                    m_lo  = 0;
                end
            end else begin
                m_hi = 0;
            end
        end else begin
            if (tx) m_lo = 0;
            else    m_lo++;
            if (m_lo >= int'(UNJAB)) begin
                m_jab = 1'b0;
                m_hi  = 0;
            end
        end
    endtask

    task automatic run(input int n, input logic tx, input logic off, input logic hd, input string tag);
        for (int i = 0; i < n; i++) step(tx, off, hd, tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        tx_en = 1'b0;
        jab_off = 1'b0;
        m_jab = 1'b0;
        m_hi  = 0;
        m_lo  = 0;
        #1;
        check_now(1'b0, 1'b0, 1'b0, tag);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compare each scoreboard entry in the middle of the low phase
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check_now(e.gate, e.flag, e.col, e.tag);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        do_reset("R10 reset state");
        run(3, 1'b0, 1'b0, 1'b1, "R10 idle after reset");

        // R1: short frames pass straight through
        for (int k = 0; k < 3; k++) begin
            run(5, 1'b1, 1'b0, 1'b1, "R1 short frame");
            run(3, 1'b0, 1'b0, 1'b1, "R1 gap");
        end

        // R2 boundary: one short of the limit
        run(JAB - 1, 1'b1, 1'b0, 1'b1, "R2 limit minus one");
        run(2, 1'b0, 1'b0, 1'b1, "R2 no trip");

        // R3: one low sample clears the run
        run(JAB - 1, 1'b1, 1'b0, 1'b1, "R3 first run");
        run(1, 1'b0, 1'b0, 1'b1, "R3 single low");
        run(JAB - 1, 1'b1, 1'b0, 1'b1, "R3 second run");
        run(2, 1'b0, 1'b0, 1'b1, "R3 no trip");

        // R2 trip, then R4 hold with R7 collision in half duplex
        run(JAB, 1'b1, 1'b0, 1'b1, "R2 trip");
        run(25, 1'b1, 1'b0, 1'b1, "R4 hold while high R7 col");
        run(5, 1'b1, 1'b0, 1'b0, "R7 full duplex no col");

        // R6: restart of the quiet count, including on the completing edge
        run(UNJAB - 1, 1'b0, 1'b0, 1'b1, "R6 quiet almost done");
        run(1, 1'b1, 1'b0, 1'b1, "R6 high on completing edge");
        run(UNJAB - 1, 1'b0, 1'b0, 1'b1, "R6 quiet restarted");
        run(1, 1'b0, 1'b0, 1'b1, "R5 last quiet sample");
        run(3, 1'b0, 1'b0, 1'b1, "R5 released");
        run(5, 1'b1, 1'b0, 1'b1, "R5 gate follows again");
        run(2, 1'b0, 1'b0, 1'b1, "R5 gap");

        // R8: disable during a jabber event
        run(JAB + 3, 1'b1, 1'b0, 1'b1, "R2 trip again");
        run(3, 1'b1, 1'b1, 1'b1, "R8 disable releases");
        run(JAB - 1, 1'b1, 1'b0, 1'b1, "R8 state discarded");
        run(2, 1'b0, 1'b0, 1'b1, "R8 gap");

        // R9: long frame with protection off, then fresh run needed
        run(60, 1'b1, 1'b1, 1'b1, "R9 long frame bypassed");
        run(JAB - 1, 1'b1, 1'b0, 1'b1, "R9 fresh run");
        run(2, 1'b0, 1'b0, 1'b1, "R9 no trip");

        // R9: disable rises on the tripping edge
        run(JAB - 1, 1'b1, 1'b0, 1'b1, "R9 near trip");
        run(1, 1'b1, 1'b1, 1'b1, "R9 disable on trip edge");
        run(JAB - 1, 1'b1, 1'b0, 1'b1, "R9 after disable");
        run(1, 1'b1, 1'b0, 1'b1, "R2 full run trips");
        run(2, 1'b1, 1'b0, 1'b1, "R4 held");

        // R10: reset in the middle of a jabber event
        do_reset("R10 reset clears jabber");
        run(4, 1'b1, 1'b0, 1'b1, "R10 gate after reset");
        run(2, 1'b0, 1'b0, 1'b1, "R10 idle");

        @(negedge clk);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule